// File: doc/BRIEF.md
# Shaper Rate Mantissa-Exponent Encoder

This block turns two 32-bit requested rates, a ceiling rate and a floor rate, into the compact decimal floating-point form used by a queue scheduling register. Each rate is reduced by repeated integer division by ten until it fits in seven bits. The number of divisions becomes a 4-bit base-10 exponent and the reduced value becomes the 7-bit mantissa. The two reductions run side by side at one division step per clock.

When both rates have been reduced, the block assembles a 32-bit register word. The word holds both encoded rates, an enable flag for each nonzero rate, a 4-bit weight and a scheduler-select bit. Three bits are copied unchanged from the prior register value. A start strobe launches an encoding. A one-cycle done pulse marks the moment the new word is on the output, and the word then holds until the next encoding finishes.

Top module: `rate_shaper_encoder`

## Requirements
- R1: A rate is reduced by truncating integer division by ten, one step per clock, while it is above 127. Each step adds one to its exponent, and reduction stops as soon as the value is 127 or less.
- R2: The ceiling rate's mantissa (the low 7 bits of its reduced value) sits in word bits [10:4] and its exponent in bits [3:0]. Bit 11 is 1 exactly when the requested ceiling rate is nonzero.
- R3: The floor rate's mantissa sits in word bits [26:20] and its exponent in bits [19:16]. Bit 27 is 1 exactly when the requested floor rate is nonzero.
- R4: The weight input appears in word bits [15:12], and the scheduler-select input appears in bit 31.
- R5: Word bits [30:28] equal bits [30:28] of the prior-word input sampled with the start strobe.
- R6: A zero rate yields an all-zero mantissa, an all-zero exponent and a cleared enable bit for that rate.
- R7: done_o is high for exactly one cycle. It rises k+1 clock edges after the edge that samples start_i, where k is the larger of the two rates' step counts.
- R8: A start strobe that arrives while an encoding is in progress is ignored. Neither the result nor the timing of the running encoding changes.
- R9: After reset, sched_word_o is 0 and done_o is 0. Between done pulses sched_word_o holds its last value.
- R10: No 32-bit rate needs more than 8 steps, so each exponent field is at most 8. An all-ones rate encodes as mantissa 42 with exponent 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launches an encoding when the block is idle |
| max_rate_i | input | 32 | Requested ceiling rate |
| min_rate_i | input | 32 | Requested floor rate |
| weight_i | input | 4 | Queue weight |
| sched_sel_i | input | 1 | Selects which of two schedulers serves the queue |
| prior_word_i | input | 32 | Prior register value; bits [30:28] are preserved |
| sched_word_o | output | 32 | Packed scheduling word |
| done_o | output | 1 | One-cycle pulse when a new word is presented |

## Verification
Directed pairs sit on each side of the reduction thresholds: 127 against 128, and 1279 against 1280. They separate an off-by-one in the "above 127" test from a correct stop, and they expose an exponent that counts one step too many or too few. Zero rates, alone and paired with an all-ones rate, check the enable bits and the exponent ceiling. Pairs of very different magnitude show that latency follows the slower of the two reductions. Random rates, scaled by random shifts across all magnitudes and carrying random weight, select and prior bits, test the field placement. A second strobe injected mid-encoding tells an ignored start apart from one that reloads the inputs.

// File: rtl/rate_enc_pkg.sv
// Package: shared field layout and sizing constants for the shaper rate
// encoder. The bit positions are fixed by the consumer of the word.
package rate_enc_pkg;
    localparam int RATE_W    = 32;
    localparam int MANT_W    = 7;
    localparam int EXP_W     = 4;
    localparam int WEIGHT_W  = 4;
    localparam int WORD_W    = 32;
    localparam int NUM_RATES = 2;

    // Index of each rate inside the reducer array
    localparam int IDX_MAX = 0;
    localparam int IDX_MIN = 1;

    // Word field positions (least significant bit of each field)
    localparam int MAX_EXP_LSB  = 0;
    localparam int MAX_MANT_LSB = 4;
    localparam int MAX_EN_BIT   = 11;
    localparam int WEIGHT_LSB   = 12;
    localparam int MIN_EXP_LSB  = 16;
    localparam int MIN_MANT_LSB = 20;
    localparam int MIN_EN_BIT   = 27;
    localparam int KEEP_LSB     = 28;
    localparam int KEEP_W       = 3;
    localparam int SEL_BIT      = 31;

    typedef enum logic {
        CTRL_IDLE = 1'b0,
        CTRL_RUN  = 1'b1
    } ctrl_state_e;
endpackage

// File: rtl/rate_reducer.sv
// Module: rate_reducer
// Holds one rate and shrinks it by integer division by ten, one step per
// enabled clock, counting the steps in an exponent register.
// Assumes: load_i and run_i are never high together; the caller keeps
// run_i high until settled_o is seen.
module rate_reducer #(
    parameter int RATE_W = 32,
    parameter int MANT_W = 7,
    parameter int EXP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              run_i,
    output logic [MANT_W-1:0] mant_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic              settled_o,
    output logic              nonzero_o
);
    localparam logic [RATE_W-1:0] LIMIT = RATE_W'((1 << MANT_W) - 1);
    localparam logic [RATE_W-1:0] TEN   = RATE_W'(10);

    logic [RATE_W-1:0] val_q;
    logic [EXP_W-1:0]  exp_q;
    logic              nz_q;

    // Reduction is finished once the value fits the mantissa
    assign settled_o = (val_q <= LIMIT);

    // Load a new rate, or take one divide-by-ten step while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            exp_q <= '0;
            nz_q  <= 1'b0;
        end else if (load_i) begin
            val_q <= rate_i;
            exp_q <= '0;
            nz_q  <= |rate_i;
        end else if (run_i && !settled_o) begin
            val_q <= val_q / TEN;
            exp_q <= exp_q + EXP_W'(1);
        end
    end

    assign mant_o    = val_q[MANT_W-1:0];
    assign exp_o     = exp_q;
    assign nonzero_o = nz_q;
endmodule

// File: rtl/enc_ctrl.sv
// Module: enc_ctrl
// Two-state sequencer: accepts a start only while idle, keeps the
// reducers running, and flags the cycle in which every reducer is settled.
// Assumes: all_settled_i is driven from registered reducer state.
module enc_ctrl
    import rate_enc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic all_settled_i,
    output logic load_o,
    output logic run_o,
    output logic finish_o
);
    ctrl_state_e state_q;

    // Strobes derived from the present state
    always_comb begin
        load_o   = (state_q == CTRL_IDLE) && start_i;
        run_o    = (state_q == CTRL_RUN);
        finish_o = (state_q == CTRL_RUN) && all_settled_i;
    end

    // State advance: idle to run on start, run to idle when settled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTRL_IDLE;
        end else begin
            case (state_q)
                CTRL_IDLE: if (start_i)       state_q <= CTRL_RUN;
                CTRL_RUN:  if (all_settled_i) state_q <= CTRL_IDLE;
                default:                      state_q <= CTRL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/word_packer.sv
// Module: word_packer
// Captures the side fields at start and, on finish, registers the packed
// scheduling word and a one-cycle done pulse.
// Assumes: load_i and capture_i are never high together.
module word_packer
    import rate_enc_pkg::*;
#(
    parameter int MANT_W   = 7,
    parameter int EXP_W    = 4,
    parameter int WEIGHT_W = 4,
    parameter int WORD_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                capture_i,
    input  logic [WEIGHT_W-1:0] weight_i,
    input  logic                sel_i,
    input  logic [WORD_W-1:0]   prior_i,
    input  logic [MANT_W-1:0]   max_mant_i,
    input  logic [EXP_W-1:0]    max_exp_i,
    input  logic                max_nz_i,
    input  logic [MANT_W-1:0]   min_mant_i,
    input  logic [EXP_W-1:0]    min_exp_i,
    input  logic                min_nz_i,
    output logic [WORD_W-1:0]   word_o,
    output logic                done_o
);
    logic [WEIGHT_W-1:0] weight_q;
    logic                sel_q;
    logic [KEEP_W-1:0]   keep_q;
    logic [WORD_W-1:0]   word_d;
    logic [WORD_W-1:0]   word_q;
    logic                done_q;

    // Latch the side fields with the accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            weight_q <= '0;
            sel_q    <= 1'b0;
            keep_q   <= '0;
        end else if (load_i) begin
            weight_q <= weight_i;
            sel_q    <= sel_i;
            keep_q   <= prior_i[KEEP_LSB +: KEEP_W];
        end
    end

    // Assemble the word from the settled reducers and the latched fields
    always_comb begin
        word_d = '0;
        word_d[MAX_EXP_LSB  +: EXP_W]    = max_exp_i;
        word_d[MAX_MANT_LSB +: MANT_W]   = max_mant_i;
        word_d[MAX_EN_BIT]               = max_nz_i;
        word_d[WEIGHT_LSB   +: WEIGHT_W] = weight_q;
        word_d[MIN_EXP_LSB  +: EXP_W]    = min_exp_i;
        word_d[MIN_MANT_LSB +: MANT_W]   = min_mant_i;
        word_d[MIN_EN_BIT]               = min_nz_i;
        word_d[KEEP_LSB     +: KEEP_W]   = keep_q;
        word_d[SEL_BIT]                  = sel_q;
    end

    // Output register: update on finish, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= capture_i;
            if (capture_i) word_q <= word_d;
        end
    end

    assign word_o = word_q;
    assign done_o = done_q;
endmodule

// File: rtl/rate_shaper_encoder.sv
// Module: rate_shaper_encoder (top)
// Encodes a ceiling and a floor rate into mantissa/exponent form in
// parallel and packs them into a queue scheduling word.
// Assumes: inputs other than start_i only matter in the cycle start_i is
// accepted.
module rate_shaper_encoder
    import rate_enc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [RATE_W-1:0]   max_rate_i,
    input  logic [RATE_W-1:0]   min_rate_i,
    input  logic [WEIGHT_W-1:0] weight_i,
    input  logic                sched_sel_i,
    input  logic [WORD_W-1:0]   prior_word_i,
    output logic [WORD_W-1:0]   sched_word_o,
    output logic                done_o
);
    logic                 load_w;
    logic                 run_w;
    logic                 finish_w;
    logic [RATE_W-1:0]    rate_w    [NUM_RATES];
    logic [MANT_W-1:0]    mant_w    [NUM_RATES];
    logic [EXP_W-1:0]     exp_w     [NUM_RATES];
    logic [NUM_RATES-1:0] settled_w;
    logic [NUM_RATES-1:0] nz_w;

    assign rate_w[IDX_MAX] = max_rate_i;
    assign rate_w[IDX_MIN] = min_rate_i;

    enc_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .all_settled_i (&settled_w),
        .load_o        (load_w),
        .run_o         (run_w),
        .finish_o      (finish_w)
    );

    // One reducer per requested rate
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_red
        rate_reducer #(
            .RATE_W (RATE_W),
            .MANT_W (MANT_W),
            .EXP_W  (EXP_W)
        ) u_red (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (load_w),
            .rate_i    (rate_w[g]),
            .run_i     (run_w),
            .mant_o    (mant_w[g]),
            .exp_o     (exp_w[g]),
            .settled_o (settled_w[g]),
            .nonzero_o (nz_w[g])
        );
    end

    word_packer #(
        .MANT_W   (MANT_W),
        .EXP_W    (EXP_W),
        .WEIGHT_W (WEIGHT_W),
        .WORD_W   (WORD_W)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_w),
        .capture_i  (finish_w),
        .weight_i   (weight_i),
        .sel_i      (sched_sel_i),
        .prior_i    (prior_word_i),
        .max_mant_i (mant_w[IDX_MAX]),
        .max_exp_i  (exp_w[IDX_MAX]),
        .max_nz_i   (nz_w[IDX_MAX]),
        .min_mant_i (mant_w[IDX_MIN]),
        .min_exp_i  (exp_w[IDX_MIN]),
        .min_nz_i   (nz_w[IDX_MIN]),
        .word_o     (sched_word_o),
        .done_o     (done_o)
    );
endmodule

// File: rtl/rate_enc_chk.sv
// Module: rate_enc_chk
// Property checker for the encoder, attached to the top by bind.
// Assumes: busy_i is the sequencer's run state.
module rate_enc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_i,
    input logic        done_i,
    input logic [31:0] word_i
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !done_i);

    // R7
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> $past(busy_i));

    // R8
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_i) |-> $past(start_i));

    // R6
    max_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !word_i[11]) |-> (word_i[10:0] == 11'd0));

    // R6
    min_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !word_i[27]) |-> (word_i[26:16] == 11'd0));

    // R10
    exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> ((word_i[3:0] <= 4'd8) && (word_i[19:16] <= 4'd8)));

    // R1
    reduced_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && (word_i[3:0] != 4'd0)) |-> (word_i[10:4] >= 7'd12));

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |-> $stable(word_i));
endmodule

bind rate_shaper_encoder rate_enc_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_i  (run_w),
    .done_i  (done_o),
    .word_i  (sched_word_o)
);

// File: tb/tb_rate_shaper_encoder.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random rates, compared with
// reference encodings computed here.
module tb_rate_shaper_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] max_rate_i = '0;
    logic [31:0] min_rate_i = '0;
    logic [3:0]  weight_i = '0;
    logic        sched_sel_i = 1'b0;
    logic [31:0] prior_word_i = '0;
    logic [31:0] sched_word_o;
    logic        done_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    rate_shaper_encoder dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .max_rate_i   (max_rate_i),
        .min_rate_i   (min_rate_i),
        .weight_i     (weight_i),
        .sched_sel_i  (sched_sel_i),
        .prior_word_i (prior_word_i),
        .sched_word_o (sched_word_o),
        .done_o       (done_o)
    );

    // Reference: number of divide-by-ten steps for a rate
    function automatic int ref_steps(input logic [31:0] r);
        int n = 0;
        logic [31:0] v = r;
        while (v > 32'd127) begin
            v = v / 32'd10;
            n++;
        end
        return n;
    endfunction

    // Reference: 12-bit field {enable, mantissa, exponent}
    function automatic logic [11:0] ref_field(input logic [31:0] r);
        int n = 0;
        logic [31:0] v = r;
        while (v > 32'd127) begin
            v = v / 32'd10;
            n++;
        end
        return {(r != 0), v[6:0], 4'(n)};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // One encoding; optionally a second start is injected while busy
    task automatic run_case(input logic [31:0] mx, input logic [31:0] mn,
                            input logic [3:0] w, input logic s,
                            input logic [31:0] pr, input bit inject);
        int n;
        int k;
        logic [11:0] fmax;
        logic [11:0] fmin;
        fmax = ref_field(mx);
        fmin = ref_field(mn);
        k = ref_steps(mx) > ref_steps(mn) ? ref_steps(mx) : ref_steps(mn);
        @(negedge clk);
        max_rate_i = mx; min_rate_i = mn; weight_i = w;
        sched_sel_i = s; prior_word_i = pr; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        if (inject) begin
            // R8: different inputs with a fresh strobe while busy
            max_rate_i = ~mx; min_rate_i = ~mn; weight_i = ~w;
            sched_sel_i = ~s; prior_word_i = ~pr; start_i = 1'b1;
        end
        while (!done_o && n < 40) begin
            @(negedge clk);
            start_i = 1'b0;
            n++;
        end
        // R7: latency counted in edges after the sampling edge
        check(inject ? "R8 latency" : "R7 latency", n, k + 1);
        check("R2 max field", {20'd0, sched_word_o[11:0]}, {20'd0, fmax});
        check("R3 min field", {20'd0, sched_word_o[27:16]}, {20'd0, fmin});
        check("R4 weight/select", {27'd0, sched_word_o[31], sched_word_o[15:12]},
              {27'd0, s, w});
        check("R5 kept bits", {29'd0, sched_word_o[30:28]}, {29'd0, pr[30:28]});
        @(negedge clk);
        check("R7 single pulse", {31'd0, done_o}, 32'd0);
        check("R9 hold", sched_word_o,
              {s, pr[30:28], fmin, w, fmax});
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (4) @(negedge clk);
        check("R9 reset word", sched_word_o, 32'd0);
        check("R9 reset done", {31'd0, done_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: thresholds
        run_case(32'd127, 32'd128, 4'h3, 1'b0, 32'h0000_0000, 1'b0);
        run_case(32'd1279, 32'd1280, 4'h5, 1'b1, 32'h7000_0000, 1'b0);
        // R6: zero rates
        run_case(32'd0, 32'd0, 4'h0, 1'b0, 32'hFFFF_FFFF, 1'b0);
        // R10: all ones with zero partner
        run_case(32'hFFFF_FFFF, 32'd0, 4'hF, 1'b1, 32'h5000_0000, 1'b0);
        check("R10 all-ones field", {20'd0, sched_word_o[11:0]},
              {20'd0, 1'b1, 7'd42, 4'd8});
        run_case(32'd0, 32'hFFFF_FFFF, 4'h9, 1'b0, 32'h2000_0000, 1'b0);
        // R7: slower reduction sets latency
        run_case(32'd5, 32'd1_000_000_000, 4'h1, 1'b1, 32'h1234_5678, 1'b0);
        // R8: start while busy, short and long encodings
        run_case(32'd100, 32'd50, 4'h6, 1'b0, 32'h4000_0000, 1'b1);
        run_case(32'd250_000, 32'd500_000, 4'h7, 1'b1, 32'h6000_0000, 1'b1);

        // Random across magnitudes
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            a = $urandom >> ($urandom % 32);
            b = $urandom >> ($urandom % 32);
            if (($urandom % 8) == 0) a = '0;
            if (($urandom % 8) == 0) b = '0;
            run_case(a, b, 4'($urandom), 1'($urandom), $urandom,
                     (($urandom % 4) == 0));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule